// File: doc/BRIEF.md
# Direct-Mapped Texel Cache

This block keeps recently used texture data close to a texture-fetch unit so that repeated texel reads do not go back to the 16-bit-per-pixel framebuffer memory. It holds 256 lines of four 16-bit words each, which is 2 KB in total. Each line covers a short horizontal run of texels. A line's width in texels, and the shape of the rectangular block of lines that tiles the 256x256 texture page, both follow the selected colour mode.

A requester presents texel coordinates (u, v) relative to the page origin. The page position and the colour mode are static inputs. The block answers with the raw texel: a 4-bit index, an 8-bit index or a 16-bit direct colour, zero-extended to 16 bits. A hit answers on the cycle after acceptance. A miss reads the four words of the line one at a time through a request/valid memory port, stores the line and then answers. The cache is emptied at once by an explicit flush or by any change of page position or colour mode.

Top module: `texcache`

## Requirements
- R1: After reset the cache is empty, so the first access to any texel misses. While idle after reset, `req_ready` is 1 and `resp_valid` and `mem_req` are 0.
- R2: A request whose line is resident and valid gives `resp_valid` for exactly one cycle, on the cycle after acceptance, with no `mem_req`.
- R3: A miss reads four framebuffer words, one outstanding at a time: `mem_req` is a one-cycle pulse and the next pulse follows the previous `mem_rvalid`. Word k (k = 0..3) is read at x = page_x*64 + L + k, where L is the line's first word column relative to the page, and at y = page_y*256 + v. `resp_valid` rises on the cycle after the fourth `mem_rvalid`.
- R4: Mode 2'b00 (4-bit indexed). A line holds 16 texels and the block is 64x64 texels. The line number is (v mod 64)*4 + (u mod 64)/16. The texel is in word (u mod 16)/4 at nibble u mod 4, where nibble 0 is bits 3:0. The result is zero-extended.
- R5: Mode 2'b01 (8-bit indexed). A line holds 8 texels and the block is 32 wide by 64 tall. The line number is (v mod 64)*4 + (u mod 32)/8. The texel is in word (u mod 8)/2; byte u mod 2 selects the byte, where byte 0 is bits 7:0. The result is zero-extended.
- R6: Modes 2'b10 and 2'b11 (15-bit direct). A line holds 4 texels and the block is 32x32. The line number is (v mod 32)*8 + (u mod 32)/4. The full 16-bit word u mod 4 of the line is returned.
- R7: Lines with different numbers stay resident together. Two texels with the same line number but in different blocks of the page evict each other.
- R8: A `flush` pulse, or any change of `page_x`, `page_y` or `tex_mode`, invalidates every line at the next clock edge, and the next access misses. `req_ready` is 0 in the cycle in which the flush or the change is present.
- R9: `req_ready` falls after acceptance and returns on the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all lines |
| tex_mode | input | 2 | Colour mode: 00 4-bit, 01 8-bit, 1x direct |
| page_x | input | 4 | Page X position in units of 64 framebuffer pixels |
| page_y | input | 1 | Page Y position in units of 256 rows |
| req_valid | input | 1 | Texel request present |
| req_ready | output | 1 | Request accepted when both are high |
| req_u | input | 8 | Texel column within the page |
| req_v | input | 8 | Texel row within the page |
| resp_valid | output | 1 | Texel result valid for one cycle |
| resp_texel | output | 16 | Raw texel, zero-extended |
| mem_req | output | 1 | Framebuffer word read pulse |
| mem_x | output | 10 | Framebuffer column of the read |
| mem_y | output | 9 | Framebuffer row of the read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 16 | Read data word |

## Verification
A wrong valid bit or a wrong tag shows at the ports on the cycle after acceptance. A line that should hit raises `mem_req`, and a line that should miss raises `resp_valid` with stale data. Wrong line numbering or a wrong tile shape shows as a wrong hit/miss pattern over a sequence of requests, or as wrong fill addresses on the first miss. Wrong word, nibble or byte selection shows in `resp_texel` on the response cycle. A reference model in the bench predicts every one of these cycle by cycle.

// File: rtl/texcache_pkg.sv
package texcache_pkg;
   localparam int TC_IDX_W = 8;
   localparam int TC_TAG_W = 6;

   typedef enum logic [1:0] {
      TM_IDX4   = 2'b00,
      TM_IDX8   = 2'b01,
      TM_DIRECT = 2'b10,
      TM_DIRALT = 2'b11
   } tmode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_RESP  = 2'd3
   } fill_st_e;
endpackage

// File: rtl/texcache_geom.sv
module texcache_geom
   import texcache_pkg::*;
#(
   parameter int COORD_W = 8,
   parameter int FBX_W   = 10,
   parameter int FBY_W   = 9
) (
   input  tmode_e                  mode,
   input  logic [COORD_W-1:0]      u,
   input  logic [COORD_W-1:0]      v,
   input  logic [FBX_W-7:0]        page_x,
   input  logic [FBY_W-COORD_W-1:0] page_y,
   output logic [TC_IDX_W-1:0]     line_idx,
   output logic [TC_TAG_W-1:0]     tag,
   output logic [FBX_W-1:0]        base_x,
   output logic [FBY_W-1:0]        row_y,
   output logic [1:0]              word_sel,
   output logic [1:0]              sub_sel
);
   logic [7:0] col;

   if (COORD_W != 8) begin : g_bad_coord
      $error("texcache_geom: page coordinates must be 8 bits");
   end

   always_comb begin
      case (mode)
         TM_IDX4: begin
            line_idx = {v[5:0], u[5:4]};
            tag      = {1'b0, u[7:6], 1'b0, v[7:6]};
            word_sel = u[3:2];
            sub_sel  = u[1:0];
            col      = {2'b00, u[7:4], 2'b00};
         end
         TM_IDX8: begin
            line_idx = {v[5:0], u[4:3]};
            tag      = {u[7:5], 1'b0, v[7:6]};
            word_sel = u[2:1];
            sub_sel  = {1'b0, u[0]};
            col      = {1'b0, u[7:3], 2'b00};
         end
         default: begin
            line_idx = {v[4:0], u[4:2]};
            tag      = {u[7:5], v[7:5]};
            word_sel = u[1:0];
            sub_sel  = 2'b00;
            col      = {u[7:2], 2'b00};
         end
      endcase
   end

   assign base_x = {page_x, 6'b000000} + {{(FBX_W-8){1'b0}}, col};
   assign row_y  = {page_y, v};
endmodule

// File: rtl/texcache_store.sv
module texcache_store #(
   parameter int N_LINES = 256,
   parameter int LINE_W  = 64,
   parameter int TAG_W   = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic [$clog2(N_LINES)-1:0] rd_idx,
   input  logic [TAG_W-1:0]           rd_tag,
   output logic                       rd_hit,
   output logic [LINE_W-1:0]          rd_line,
   input  logic                       we,
   input  logic [$clog2(N_LINES)-1:0] wr_idx,
   input  logic [TAG_W-1:0]           wr_tag,
   input  logic [LINE_W-1:0]          wr_line
);
   localparam int IDX_W = $clog2(N_LINES);

   logic [LINE_W-1:0] data_q [N_LINES];
   logic [TAG_W-1:0]  tag_q  [N_LINES];
   logic [N_LINES-1:0] vld_q;

   always_ff @(posedge clk) begin
      if (we) begin
         data_q[wr_idx] <= wr_line;
         tag_q[wr_idx]  <= wr_tag;
      end
   end

   for (genvar i = 0; i < N_LINES; i++) begin : g_vld
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             vld_q[i] <= 1'b0;
         else if (clear)                         vld_q[i] <= 1'b0;
         else if (we && wr_idx == IDX_W'(i))     vld_q[i] <= 1'b1;
      end
   end

   assign rd_hit  = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   assign rd_line = data_q[rd_idx];

   p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (vld_q == '0));

   p_fill_sets_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !clear) |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/texcache_fill.sv
module texcache_fill
   import texcache_pkg::*;
#(
   parameter int PIX_W      = 16,
   parameter int LINE_WORDS = 4,
   parameter int FBX_W      = 10,
   parameter int FBY_W      = 9
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        accept,
   input  logic                        hit,
   input  logic [PIX_W*LINE_WORDS-1:0] hit_line,
   input  logic [FBX_W-1:0]            start_x,
   input  logic [FBY_W-1:0]            start_y,
   input  logic                        mem_rvalid,
   input  logic [PIX_W-1:0]            mem_rdata,
   output logic                        mem_req,
   output logic [FBX_W-1:0]            mem_x,
   output logic [FBY_W-1:0]            mem_y,
   output logic                        fill_we,
   output logic [PIX_W*LINE_WORDS-1:0] fill_line,
   output logic [PIX_W*LINE_WORDS-1:0] line_buf,
   output logic                        idle,
   output logic                        resp_valid
);
   localparam int LINE_W = PIX_W * LINE_WORDS;
   localparam int CNT_W  = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_WORDS - 1);

   fill_st_e           st_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [FBX_W-1:0]   x_q;
   logic [FBY_W-1:0]   y_q;
   logic [LINE_W-1:0]  buf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         x_q   <= '0;
         y_q   <= '0;
         buf_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (accept) begin
               x_q   <= start_x;
               y_q   <= start_y;
               cnt_q <= '0;
               if (hit) begin
                  buf_q <= hit_line;
                  st_q  <= ST_RESP;
               end else begin
                  st_q  <= ST_ISSUE;
               end
            end
            ST_ISSUE: st_q <= ST_WAIT;
            ST_WAIT: if (mem_rvalid) begin
               buf_q[int'(cnt_q)*PIX_W +: PIX_W] <= mem_rdata;
               if (cnt_q == LAST) begin
                  st_q <= ST_RESP;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
                  st_q  <= ST_ISSUE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      fill_line = buf_q;
      fill_line[int'(LAST)*PIX_W +: PIX_W] = mem_rdata;
   end

   assign mem_req    = (st_q == ST_ISSUE);
   assign mem_x      = x_q + FBX_W'(cnt_q);
   assign mem_y      = y_q;
   assign fill_we    = (st_q == ST_WAIT) && mem_rvalid && (cnt_q == LAST);
   assign line_buf   = buf_q;
   assign idle       = (st_q == ST_IDLE);
   assign resp_valid = (st_q == ST_RESP);

   p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   p_resp_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> ($past(mem_rvalid) || $past(accept)));

   p_ready_after_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> idle);

   p_single_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);
endmodule

// File: rtl/texcache.sv
module texcache
   import texcache_pkg::*;
#(
   parameter int PIX_W      = 16,
   parameter int LINE_WORDS = 4,
   parameter int N_LINES    = 256,
   parameter int FBX_W      = 10,
   parameter int FBY_W      = 9,
   parameter int COORD_W    = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic [1:0]                 tex_mode,
   input  logic [FBX_W-7:0]           page_x,
   input  logic [FBY_W-COORD_W-1:0]   page_y,
   input  logic                       req_valid,
   output logic                       req_ready,
   input  logic [COORD_W-1:0]         req_u,
   input  logic [COORD_W-1:0]         req_v,
   output logic                       resp_valid,
   output logic [PIX_W-1:0]           resp_texel,
   output logic                       mem_req,
   output logic [FBX_W-1:0]           mem_x,
   output logic [FBY_W-1:0]           mem_y,
   input  logic                       mem_rvalid,
   input  logic [PIX_W-1:0]           mem_rdata
);
   localparam int LINE_W = PIX_W * LINE_WORDS;
   localparam int CFG_W  = 2 + (FBX_W - 6) + (FBY_W - COORD_W);

   if (PIX_W != 16 || LINE_WORDS != 4) begin : g_bad_line
      $error("texcache: a line must be four 16-bit words");
   end
   if (N_LINES != (1 << TC_IDX_W)) begin : g_bad_depth
      $error("texcache: line count must match the tile numbering");
   end
   if (FBX_W < 8 || FBY_W <= COORD_W) begin : g_bad_fb
      $error("texcache: framebuffer too small for a texture page");
   end

   tmode_e                mode;
   logic [CFG_W-1:0]      cfg_now, cfg_q;
   logic                  cfg_chg, clear, accept;
   logic [TC_IDX_W-1:0]   g_idx, idx_q;
   logic [TC_TAG_W-1:0]   g_tag, tag_q;
   logic [FBX_W-1:0]      g_x;
   logic [FBY_W-1:0]      g_y;
   logic [1:0]            g_word, g_sub, word_q, sub_q;
   tmode_e                mode_q;
   logic                  hit, fill_we, idle;
   logic [LINE_W-1:0]     hit_line, fill_line, line_buf;
   logic [PIX_W-1:0]      word_w;

   assign mode    = tmode_e'(tex_mode);
   assign cfg_now = {tex_mode, page_x, page_y};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_now;
   end

   assign cfg_chg   = (cfg_now != cfg_q);
   assign clear     = flush || cfg_chg;
   assign req_ready = idle && !clear;
   assign accept    = req_valid && req_ready;

   texcache_geom #(.COORD_W(COORD_W), .FBX_W(FBX_W), .FBY_W(FBY_W)) u_geom (
      .mode(mode), .u(req_u), .v(req_v), .page_x(page_x), .page_y(page_y),
      .line_idx(g_idx), .tag(g_tag), .base_x(g_x), .row_y(g_y),
      .word_sel(g_word), .sub_sel(g_sub)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         tag_q  <= '0;
         word_q <= '0;
         sub_q  <= '0;
         mode_q <= TM_IDX4;
      end else if (accept) begin
         idx_q  <= g_idx;
         tag_q  <= g_tag;
         word_q <= g_word;
         sub_q  <= g_sub;
         mode_q <= mode;
      end
   end

   texcache_store #(.N_LINES(N_LINES), .LINE_W(LINE_W), .TAG_W(TC_TAG_W)) u_store (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .rd_idx(g_idx), .rd_tag(g_tag), .rd_hit(hit), .rd_line(hit_line),
      .we(fill_we), .wr_idx(idx_q), .wr_tag(tag_q), .wr_line(fill_line)
   );

   texcache_fill #(.PIX_W(PIX_W), .LINE_WORDS(LINE_WORDS), .FBX_W(FBX_W), .FBY_W(FBY_W)) u_fill (
      .clk(clk), .rst_n(rst_n), .accept(accept), .hit(hit), .hit_line(hit_line),
      .start_x(g_x), .start_y(g_y), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .mem_req(mem_req), .mem_x(mem_x), .mem_y(mem_y), .fill_we(fill_we),
      .fill_line(fill_line), .line_buf(line_buf), .idle(idle), .resp_valid(resp_valid)
   );

   assign word_w = line_buf[int'(word_q)*PIX_W +: PIX_W];

   always_comb begin
      case (mode_q)
         TM_IDX4: resp_texel = PIX_W'(word_w[int'(sub_q)*4 +: 4]);
         TM_IDX8: resp_texel = PIX_W'(word_w[int'(sub_q[0])*8 +: 8]);
         default: resp_texel = word_w;
      endcase
   end

   p_hit_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && hit) |=> !mem_req);

   p_miss_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !hit) |=> mem_req);

   p_clear_blocks_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |-> !req_ready);
endmodule

// File: tb/texcache_bench.sv
module texcache_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [1:0]  tex_mode = 2'b00;
   logic [3:0]  page_x = 4'd0;
   logic        page_y = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [7:0]  req_u = 8'd0;
   logic [7:0]  req_v = 8'd0;
   logic        resp_valid;
   logic [15:0] resp_texel;
   logic        mem_req;
   logic [9:0]  mem_x;
   logic [8:0]  mem_y;
   logic        mem_rvalid = 1'b0;
   logic [15:0] mem_rdata = 16'd0;

   int checks = 0;
   int errors = 0;
   int mtag [256];
   bit mval [256];
   int cur_mode = 0, cur_px = 0, cur_py = 0;

   always #5 clk = ~clk;

   texcache u_texcache (
      .clk(clk), .rst_n(rst_n), .flush(flush), .tex_mode(tex_mode),
      .page_x(page_x), .page_y(page_y), .req_valid(req_valid), .req_ready(req_ready),
      .req_u(req_u), .req_v(req_v), .resp_valid(resp_valid), .resp_texel(resp_texel),
      .mem_req(mem_req), .mem_x(mem_x), .mem_y(mem_y),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   function automatic int fbword(int x, int y);
      return (x * 37 + y * 101 + 23100) % 65536;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < 256; i++) mval[i] = 1'b0;
   endtask

   task automatic set_cfg(int m, int px, int py);
      @(negedge clk);
      tex_mode = 2'(m); page_x = 4'(px); page_y = 1'(py);
      if (m != cur_mode || px != cur_px || py != cur_py) begin
         model_clear();
         #1 chk("R8", "req_ready during config change", int'(req_ready), 0);
      end
      cur_mode = m; cur_px = px; cur_py = py;
      @(negedge clk);
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      model_clear();
      #1 chk("R8", "req_ready during flush", int'(req_ready), 0);
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic txn(int u, int v, string hreq);
      int tpw, bw, bh, lpr, line, tg, lx, y, w, tex;
      bit hit;
      string treq;
      tpw  = (cur_mode == 0) ? 4 : (cur_mode == 1) ? 2 : 1;
      bw   = (cur_mode == 0) ? 64 : 32;
      bh   = (cur_mode >= 2) ? 32 : 64;
      lpr  = bw / (4 * tpw);
      line = (v % bh) * lpr + (u % bw) / (4 * tpw);
      tg   = (u / bw) * 16 + (v / bh);
      hit  = mval[line] && (mtag[line] == tg);
      mval[line] = 1'b1;
      mtag[line] = tg;
      lx = (cur_px * 64 + (u / (4 * tpw)) * 4) % 1024;
      y  = cur_py * 256 + v;
      w  = fbword((cur_px * 64 + u / tpw) % 1024, y);
      if (cur_mode == 0)      begin tex = (w >> (4 * (u % 4))) & 15;  treq = "R4"; end
      else if (cur_mode == 1) begin tex = (w >> (8 * (u % 2))) & 255; treq = "R5"; end
      else                    begin tex = w;                          treq = "R6"; end

      @(negedge clk);
      req_u = 8'(u); req_v = 8'(v); req_valid = 1'b1;
      #1 chk("R9", "req_ready when idle", int'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9", "req_ready after accept", int'(req_ready), 0);
      chk(hreq, "memory read (hit/miss)", int'(mem_req), hit ? 0 : 1);
      if (hit) begin
         chk("R2", "resp_valid on hit", int'(resp_valid), 1);
         chk(treq, "texel on hit", int'(resp_texel), tex);
      end else begin
         for (int k = 0; k < 4; k++) begin
            chk("R3", "read pulse", int'(mem_req), 1);
            chk("R3", "read x", int'(mem_x), (lx + k) % 1024);
            chk("R3", "read y", int'(mem_y), y);
            chk("R3", "no early response", int'(resp_valid), 0);
            @(negedge clk);
            chk("R3", "read is a pulse", int'(mem_req), 0);
            @(negedge clk);
            chk("R3", "no read while waiting", int'(mem_req), 0);
            mem_rvalid = 1'b1;
            mem_rdata  = 16'(fbword((lx + k) % 1024, y));
            @(negedge clk);
            mem_rvalid = 1'b0;
         end
         chk("R3", "resp_valid after fourth word", int'(resp_valid), 1);
         chk(treq, "texel on miss", int'(resp_texel), tex);
      end
      @(negedge clk);
      chk("R9", "single-cycle response", int'(resp_valid), 0);
      chk("R9", "req_ready after response", int'(req_ready), 1);
   endtask

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "req_ready after reset", int'(req_ready), 1);
      chk("R1", "resp_valid after reset", int'(resp_valid), 0);
      chk("R1", "mem_req after reset", int'(mem_req), 0);

      set_cfg(0, 3, 0);
      txn(5, 7, "R1");
      txn(6, 7, "R2");
      txn(7, 7, "R2");
      txn(4, 7, "R2");
      txn(17, 7, "R7");
      txn(5, 7, "R7");
      txn(69, 7, "R7");
      txn(5, 7, "R7");
      txn(5, 8, "R7");
      do_flush();
      txn(5, 7, "R8");

      set_cfg(1, 3, 0);
      txn(5, 7, "R8");
      txn(4, 7, "R5");
      txn(37, 7, "R7");
      set_cfg(1, 5, 1);
      txn(4, 7, "R8");
      txn(3, 7, "R5");

      set_cfg(2, 2, 0);
      txn(9, 200, "R8");
      txn(10, 200, "R6");
      txn(41, 200, "R7");
      txn(9, 232, "R7");
      set_cfg(3, 2, 0);
      txn(9, 200, "R8");
      txn(11, 200, "R6");

      for (int m = 0; m < 3; m++) begin
         set_cfg(m, 1, m % 2);
         for (int i = 0; i < 30; i++) begin
            txn((i * 53 + 11) % 256, (i * 29 + 3) % 64, "R7");
            if (i % 4 == 0) txn((i * 53 + 12) % 256, (i * 29 + 3) % 64, "R7");
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule